// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked host to an external asynchronous static RAM that is 32768 words deep and 16 bits wide, with a separate select for each byte lane. The host gives one transfer at a time: a request strobe, a direction flag, a word address, write data and a two-bit byte enable. The controller registers the request. It then plays out the memory's strobes, holding each phase for a whole number of clock cycles, and reports completion with a one-cycle done pulse. For reads it also returns the captured word.

Each transfer follows the same state path: `ST_IDLE` → `ST_SETUP` → `ST_STROBE` → `ST_RECOVER` → `ST_IDLE`. `ST_IDLE` → `ST_SETUP` is taken when a request arrives while ready is high. `ST_SETUP` → `ST_STROBE` and `ST_STROBE` → `ST_RECOVER` are taken when the phase counter reaches zero. `ST_RECOVER` → `ST_IDLE` is taken when the recovery count ends.

- In `ST_SETUP`, chip select and the enabled lane selects fall while the address settles.
- In `ST_STROBE`, write enable is held low for a write. For a read, output enable is held low and the controller waits for the access time.
- In `ST_RECOVER`, every strobe is high again. For a write, the data stays driven through this state.

Phase lengths come from nanosecond parameters and the clock period. Each is rounded up and never falls below one cycle.

The memory data bus is split into an input, an output and an output-enable, so that a pad ring can build the tristate.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, chip select, write enable, output enable and both lane selects are high (inactive). The data driver is off, ready is 1, done is 0 and read data is 0.
- R2: Ready is high only in `ST_IDLE`. A request seen while ready is low is ignored: it does not alter the address, the data or the strobe sequence of the transfer in progress, and it is not queued.
- R3: An accepted transfer stays busy for exactly setup + strobe + recovery cycles. Done is then high for one cycle, in the first cycle that ready is high again, and a new request may be accepted in that same cycle.
- R4: For a write, write enable is low for exactly the write-pulse cycle count. It falls only after chip select has already been low for the setup phase, and it rises together with chip select.
- R5: The memory address, and for writes the driven data, are loaded at acceptance and stay unchanged for the whole transfer.
- R6: Output enable stays high throughout every write. During a read it is low for exactly the access-wait cycle count.
- R7: The controller drives the data bus only in the setup, strobe and recovery phases of a write. It drives only when output enable is high in the current cycle and was high in the previous cycle.
- R8: Lane select bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A lane select is low during setup and strobe only when the matching byte-enable bit is 1, and never while chip select is high.
- R9: Read data is registered at the end of the last access-wait cycle. A lane whose enable bit is 0 reads as 0x00. The value holds until the next read capture.
- R10: The cycle counts are max(1, ceil(ns / clock period)). With the default 8 ns clock they give 1 setup cycle, 2 write-pulse cycles, 2 access-wait cycles and 1 recovery cycle. A write therefore takes 4 busy cycles and a read takes 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Transfer request, taken when ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 15 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enable, bit 0 = lower lane |
| host_ready | output | 1 | Idle and able to accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Registered read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Byte-lane selects, active low, bit 0 = lower |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 16 | Data to the memory |
| mem_dq_i | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The assertions check the bus-safety rules on every clock:
- write enable never falls before chip select is low;
- the address and write data never move inside an active cycle;
- the data drivers never turn on unless output enable has been high for two cycles;
- lane selects never fall outside chip select;
- done never lasts beyond one cycle;
- read data never changes outside a capture.

Other behaviour can only be shown by the bench's scenarios, using a behavioural memory and a cycle-level reference:
- the exact phase lengths;
- requests ignored while busy;
- masking of individual lanes on writes and reads;
- the read-back of partial writes;
- transfers issued back to back in the done cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } sram_state_e;

    // Whole clock cycles needed to cover a duration, never below one.
    function automatic int cycles_for(input int dur_ns, input int period_ns);
        int c;
        c = (dur_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int WRITE_CYC = 2,
    parameter int READ_CYC  = 2,
    parameter int RECOV_CYC = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        op_wr,
    output sram_state_e state_q,
    output sram_state_e state_d,
    output logic        last
);

    localparam int MAX_A   = (SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC;
    localparam int MAX_B   = (WRITE_CYC > READ_CYC) ? WRITE_CYC : READ_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign last = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (last) begin
                    state_d = ST_STROBE;
                    cnt_d   = op_wr ? CNT_W'(WRITE_CYC - 1) : CNT_W'(READ_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (last) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(RECOV_CYC - 1);
                end
            end
            ST_RECOVER: begin
                if (last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R2: without an accepted request the sequencer stays idle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !accept) |=> (state_q == ST_IDLE));

    // R3: the end of setup always leads into the strobe phase
    a_r3_setup_to_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETUP && last) |=> (state_q == ST_STROBE));

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_d,
    input  logic       capture,
    input  logic       en_q,
    input  logic [7:0] dq_in,
    output logic       lane_n,
    output logic [7:0] rd_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_n  <= 1'b1;
            rd_byte <= '0;
        end else begin
            lane_n <= !sel_d;
            if (capture) begin
                rd_byte <= en_q ? dq_in : 8'h00;
            end
        end
    end

    // R9: the captured byte changes only at a capture edge
    a_r9_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_byte));

    // R9: a disabled lane captures zero
    a_r9_zero_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !en_q) |=> (rd_byte == 8'h00));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 16,
    parameter int CLK_NS        = 8,
    parameter int ADDR_SETUP_NS = 0,
    parameter int WE_PULSE_NS   = 9,
    parameter int ACCESS_NS     = 10,
    parameter int RECOVER_NS    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic [DATA_W/8-1:0]  host_be,
    output logic                 host_ready,
    output logic                 host_done,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 mem_cs_n,
    output logic                 mem_we_n,
    output logic                 mem_oe_n,
    output logic [DATA_W/8-1:0]  mem_lane_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_o,
    input  logic [DATA_W-1:0]    mem_dq_i,
    output logic                 mem_dq_oe
);

    localparam int LANES     = DATA_W / 8;
    localparam int SETUP_CYC = cycles_for(ADDR_SETUP_NS, CLK_NS);
    localparam int WRITE_CYC = cycles_for(WE_PULSE_NS, CLK_NS);
    localparam int READ_CYC  = cycles_for(ACCESS_NS, CLK_NS);
    localparam int RECOV_CYC = cycles_for(RECOVER_NS, CLK_NS);

    sram_state_e      state_q, state_d;
    logic             last;
    logic             accept;
    logic             wr_q, wr_d;
    logic [LANES-1:0] be_q, be_d;
    logic             active_d;
    logic             capture;

    assign host_ready = (state_q == ST_IDLE);
    assign accept     = host_ready && host_req;
    assign wr_d       = accept ? host_wr : wr_q;
    assign be_d       = accept ? host_be : be_q;
    assign active_d   = (state_d == ST_SETUP) || (state_d == ST_STROBE);
    assign capture    = (state_q == ST_STROBE) && last && !wr_q;

    sram_ctrl_seq #(
        .SETUP_CYC (SETUP_CYC),
        .WRITE_CYC (WRITE_CYC),
        .READ_CYC  (READ_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .op_wr   (wr_q),
        .state_q (state_q),
        .state_d (state_d),
        .last    (last)
    );

    // Request capture: address and data are held for the whole transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            be_q     <= '0;
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            wr_q     <= host_wr;
            be_q     <= host_be;
            mem_addr <= host_addr;
            mem_dq_o <= host_wdata;
        end
    end

    // Registered strobes decoded from the next state, so no pin can glitch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            host_done <= 1'b0;
        end else begin
            mem_cs_n  <= !active_d;
            mem_we_n  <= !((state_d == ST_STROBE) && wr_d);
            mem_oe_n  <= !((state_d == ST_STROBE) && !wr_d);
            mem_dq_oe <= (state_d != ST_IDLE) && wr_d;
            host_done <= (state_q == ST_RECOVER) && last;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_ctrl_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_d   (active_d && be_d[i]),
            .capture (capture),
            .en_q    (be_q[i]),
            .dq_in   (mem_dq_i[i*8 +: 8]),
            .lane_n  (mem_lane_n[i]),
            .rd_byte (host_rdata[i*8 +: 8])
        );
    end

    // R4: write enable may fall only once chip select is already low
    a_r4_we_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_cs_n));

    // R4: write enable is never low outside chip select
    a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    // R5: address is frozen while chip select stays low
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    // R5: driven data is frozen while the driver stays on
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    // R6: no read strobe during a write pulse
    a_r6_no_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R7: drivers on only after output enable has been high two cycles
    a_r7_drive_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

    // R8: lane selects never fall outside chip select
    a_r8_lane_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lane_n != '1) |-> !mem_cs_n);

    // R3: done is a single-cycle pulse seen while ready
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> (host_ready ##1 !host_done));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    localparam int PER = 8;

    function automatic int ncyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    // R10: expected phase lengths from the rounding rule
    localparam int S_C = ncyc(0);
    localparam int W_C = ncyc(9);
    localparam int A_C = ncyc(10);
    localparam int R_C = ncyc(5);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [14:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready, host_done;
    logic [15:0] host_rdata;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [14:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #(PER/2) clk = ~clk;

    sram_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .host_ready (host_ready),
        .host_done  (host_done),
        .host_rdata (host_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_lane_n (mem_lane_n),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .mem_dq_i   (mem_dq_i),
        .mem_dq_oe  (mem_dq_oe)
    );

    function automatic logic [15:0] init_word(input int a);
        return {8'(a) ^ 8'h3C, 8'(a >> 7) ^ 8'hC5};
    endfunction

    // ---------------- pin-level memory model ----------------
    logic [15:0] sram_mem [int];
    bit          pend = 0;
    int          pend_a;
    logic [15:0] pend_d;
    logic [1:0]  pend_l;

    function automatic logic [15:0] sram_rd(input int a);
        return sram_mem.exists(a) ? sram_mem[a] : init_word(a);
    endfunction

    always @(mem_cs_n or mem_we_n or mem_oe_n or mem_lane_n or mem_addr or pend) begin
        logic [15:0] w;
        w = sram_rd(int'(mem_addr));
        if (!mem_cs_n && mem_we_n && !mem_oe_n) begin
            mem_dq_i[7:0]  = mem_lane_n[0] ? 8'hEE : w[7:0];
            mem_dq_i[15:8] = mem_lane_n[1] ? 8'hEE : w[15:8];
        end else begin
            mem_dq_i = 16'hD1D1;
        end
    end

    always @(negedge clk) begin
        if (!mem_we_n && !mem_cs_n) begin
            pend   = 1;
            pend_a = int'(mem_addr);
            pend_d = mem_dq_o;
            pend_l = mem_lane_n;
        end else if (pend) begin
            logic [15:0] w;
            w = sram_rd(pend_a);
            if (!pend_l[0]) w[7:0]  = pend_d[7:0];
            if (!pend_l[1]) w[15:8] = pend_d[15:8];
            sram_mem[pend_a] = w;
            pend = 0;
        end
    end

    // ---------------- cycle-level reference ----------------
    logic [15:0] mdl_mem [int];
    bit          busy = 0;
    int          t = 0;
    bit          m_wr = 0;
    logic [14:0] m_addr = '0;
    logic [15:0] m_wd = '0;
    logic [1:0]  m_be = '0;
    bit          m_done = 0;
    logic [15:0] rd_exp = '0;

    function automatic logic [15:0] mdl_rd(input int a);
        return mdl_mem.exists(a) ? mdl_mem[a] : init_word(a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; t = 0; m_done = 0; rd_exp = '0;
        end else begin
            bit was_busy;
            int sl;
            was_busy = busy;
            m_done = 0;
            if (busy) begin
                sl = m_wr ? W_C : A_C;
                if (t == S_C + sl) begin
                    logic [15:0] w;
                    w = mdl_rd(int'(m_addr));
                    if (m_wr) begin
                        if (m_be[0]) w[7:0]  = m_wd[7:0];
                        if (m_be[1]) w[15:8] = m_wd[15:8];
                        mdl_mem[int'(m_addr)] = w;
                    end else begin
                        rd_exp = {m_be[1] ? w[15:8] : 8'h00, m_be[0] ? w[7:0] : 8'h00};
                    end
                end
                if (t == S_C + sl + R_C) begin
                    busy = 0; m_done = 1;
                end else begin
                    t++;
                end
            end
            if (!was_busy && host_req) begin
                busy = 1; t = 1;
                m_wr = host_wr; m_addr = host_addr; m_wd = host_wdata; m_be = host_be;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int sl;
        bit act, strb;
        cyc++;
        sl   = m_wr ? W_C : A_C;
        act  = busy && (t <= S_C + sl);
        strb = busy && (t > S_C) && (t <= S_C + sl);
        if (!rst_n) begin
            chk("R1", "cs_n", 32'(mem_cs_n), 32'd1);
            chk("R1", "we_n", 32'(mem_we_n), 32'd1);
            chk("R1", "oe_n", 32'(mem_oe_n), 32'd1);
            chk("R1", "lane_n", 32'(mem_lane_n), 32'd3);
            chk("R1", "dq_oe", 32'(mem_dq_oe), 32'd0);
            chk("R1", "ready", 32'(host_ready), 32'd1);
            chk("R1", "done", 32'(host_done), 32'd0);
            chk("R1", "rdata", 32'(host_rdata), 32'd0);
        end else begin
            chk("R3 R10 R2", "ready", 32'(host_ready), 32'(!busy));
            chk("R3", "done", 32'(host_done), 32'(m_done));
            chk("R8", "cs_n", 32'(mem_cs_n), 32'(!act));
            chk("R4", "we_n", 32'(mem_we_n), 32'(!(strb && m_wr)));
            chk("R6", "oe_n", 32'(mem_oe_n), 32'(!(strb && !m_wr)));
            chk("R7", "dq_oe", 32'(mem_dq_oe), 32'(busy && m_wr));
            chk("R8", "lane_n", 32'(mem_lane_n),
                32'({!(act && m_be[1]), !(act && m_be[0])}));
            chk("R9", "rdata", 32'(host_rdata), 32'(rd_exp));
            if (busy) chk("R5", "addr", 32'(mem_addr), 32'(m_addr));
            if (busy && m_wr) chk("R5", "dq_o", 32'(mem_dq_o), 32'(m_wd));
        end
    end

    // ---------------- stimulus ----------------
    task automatic xfer(input bit wr, input logic [14:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int junk_cycles);
        while (!host_ready) @(negedge clk);
        host_req = 1; host_wr = wr; host_addr = a; host_wdata = d; host_be = be;
        @(negedge clk);
        for (int k = 0; k < junk_cycles; k++) begin
            host_wr = ~wr; host_addr = ~a; host_wdata = ~d; host_be = ~be;
            @(negedge clk);
        end
        host_req = 0;
        while (!host_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: a write occupies the derived number of busy cycles
        xfer(1, 15'd5, 16'h1234, 2'b11, 0);
        xfer(0, 15'd5, 16'h0000, 2'b11, 0);
        chk("R9", "readback full", 32'(host_rdata), 32'h1234);
        // R8: lower-lane-only write
        xfer(1, 15'd5, 16'hAB77, 2'b01, 0);
        xfer(0, 15'd5, 16'h0000, 2'b11, 0);
        chk("R8", "lower lane write", 32'(host_rdata), 32'h1277);
        // R8: upper-lane-only write
        xfer(1, 15'd5, 16'h99FF, 2'b10, 0);
        xfer(0, 15'd5, 16'h0000, 2'b01, 0);
        chk("R9", "lower lane read", 32'(host_rdata), 32'h0077);
        xfer(0, 15'd5, 16'h0000, 2'b10, 0);
        chk("R9", "upper lane read", 32'(host_rdata), 32'h9900);
        xfer(0, 15'd5, 16'h0000, 2'b00, 0);
        chk("R9", "no lane read", 32'(host_rdata), 32'h0000);
        // boundary addresses
        xfer(0, 15'h7FFF, 16'h0000, 2'b11, 0);
        chk("R9", "unwritten top", 32'(host_rdata), 32'(init_word(32'h7FFF)));
        xfer(1, 15'h7FFF, 16'hC0DE, 2'b11, 0);
        xfer(1, 15'h0000, 16'h5EED, 2'b11, 0);
        xfer(0, 15'h7FFF, 16'h0000, 2'b11, 0);
        chk("R5", "top address", 32'(host_rdata), 32'hC0DE);
        // R2: requests during busy with altered fields are ignored
        xfer(1, 15'h0123, 16'h4242, 2'b11, 2);
        xfer(0, 15'h0123, 16'h0000, 2'b11, 2);
        chk("R2", "busy request ignored", 32'(host_rdata), 32'h4242);
        xfer(0, 15'h7EDC, 16'h0000, 2'b11, 0);
        chk("R2", "ignored write absent", 32'(host_rdata), 32'(init_word(32'h7EDC)));
        // R3: request held high gives back-to-back transfers in the done cycle
        while (!host_ready) @(negedge clk);
        host_req = 1; host_wr = 1; host_addr = 15'h0200; host_wdata = 16'hA5A5; host_be = 2'b11;
        repeat (12) @(negedge clk);
        host_wr = 0;
        repeat (9) @(negedge clk);
        host_req = 0;
        while (!host_ready) @(negedge clk);
        chk("R9", "stream read", 32'(host_rdata), 32'hA5A5);
        // R6 R7: alternate read and write back to back
        xfer(0, 15'h0000, 16'h0000, 2'b11, 0);
        xfer(1, 15'h0001, 16'h0F0F, 2'b11, 0);
        xfer(0, 15'h0001, 16'h0000, 2'b11, 0);
        chk("R6", "alternating", 32'(host_rdata), 32'h0F0F);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule